// File: doc/BRIEF.md
# Receive Time-Stamp Unit

This block keeps one free-running time base for a bank of serial receivers and records, for each receiver, the instant at which it finished a word. A microsecond base is made either by dividing the system clock or by counting rising edges of an external reference input. A second divider then stretches that base by a host-chosen factor of 1 to 255, and each stretched tick advances a counter that wraps silently when it overflows. Whenever a receiver raises its completion strobe, the counter value of that cycle goes into a small first-word-fall-through queue owned by that receiver.

The host controls the unit through plain ports. It picks the reference source, sets the resolution and clears the counter with a pulse. An external reset line can also clear the counter when the host has armed it. The live value comes out in two halves. A read of the lower half freezes the upper half, so a two-access read always gives a matching pair. Receiver framing and bus decoding live in other blocks.

Top module: `rx_stamp_unit`

## Requirements
- R1: After reset the counter is zero, both host read halves are zero, every queue is empty and no queue reports full.
- R2: With the internal source selected and resolution value N in 1..255, the counter reads floor(k / (CLK_PER_US*N)) in the k-th cycle after the cycle in which a clear was taken (k = 0 is the first cycle with the cleared value).
- R3: A resolution value of 0 behaves exactly like a value of 1.
- R4: With src_sel_i = 1 the microsecond base is the rising edge of ext_clk_i after a two-stage synchroniser, and the system-clock divider has no effect on the count. N rising edges then make one count step.
- R5: A host_clr_i pulse sets the counter to zero on the next clock edge and restarts both dividers. It wins over a tick in the same cycle.
- R6: With ext_rst_en_i = 1, a rising edge of ext_rst_i clears the counter and restarts the dividers on the third clock edge after the input rises. With ext_rst_en_i = 0 the input has no effect on the count.
- R7: The counter steps from all ones to zero without any other effect.
- R8: A strobe on rx_strobe_i[i] pushes the counter value of that same cycle into queue i. Queue i shows its oldest entry on its slice of rx_stamp_o (bits i*CNT_W upward), and rx_pop_i[i] drops that entry. Entries leave in arrival order.
- R9: Receivers that strobe in the same cycle all store the identical value.
- R10: A strobe into a full queue is dropped and leaves its contents unchanged. A pop of an empty queue is ignored.
- R11: host_lo_o shows the lower half of the live counter. A host_rd_lo_i pulse copies the upper half of the counter in that cycle to host_hi_o, which then holds until the next such pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Reference source: 0 internal divider, 1 external input |
| res_i | input | RES_W | Resolution in microseconds per count (0 acts as 1) |
| ext_clk_i | input | 1 | External microsecond reference, asynchronous |
| ext_rst_i | input | 1 | External counter reset, asynchronous, rising edge |
| ext_rst_en_i | input | 1 | Arms the external reset |
| host_clr_i | input | 1 | Host clear pulse |
| host_rd_lo_i | input | 1 | Host read of the low half; freezes the high half |
| host_lo_o | output | CNT_W/2 | Live low half of the counter |
| host_hi_o | output | CNT_W/2 | High half frozen at the last low-half read |
| rx_strobe_i | input | NUM_RX | Word-complete strobes, one per receiver |
| rx_pop_i | input | NUM_RX | Pop strobes, one per receiver queue |
| rx_stamp_o | output | NUM_RX*CNT_W | Head entry of every receiver queue |
| rx_empty_o | output | NUM_RX | Queue empty flags |
| rx_full_o | output | NUM_RX | Queue full flags |

## Verification
A fault in either divider shows up on host_lo_o as a step arriving one or more cycles early or late. With a small divide ratio this happens within a few tens of cycles after a clear, so the bench compares the count against the closed-form value in every cycle of several resolution settings. Bad synchroniser or reset-arming logic shows as a clear arriving on the wrong edge, or arriving at all when the reset is disarmed, and the check is made in the exact cycle. Queue pointer faults show as heads in the wrong order, lost or extra entries, or a changed head after a push into a full queue, and a pop sequence that follows immediately exposes them.

// File: rtl/rx_stamp_pkg.sv
package rx_stamp_pkg;

   typedef enum logic {
      SRC_INTERNAL = 1'b0,
      SRC_EXTERNAL = 1'b1
   } stamp_src_e;

endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("stamp_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/stamp_prescaler.sv
module stamp_prescaler
   import rx_stamp_pkg::*;
#(
   parameter int CLK_PER_US = 50,
   parameter int RES_W      = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  stamp_src_e       src_i,
   input  logic             ext_us_i,
   input  logic [RES_W-1:0] res_i,
   output logic             tick_o
);

   localparam int US_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   if (CLK_PER_US < 1) begin : g_bad_div
      $error("stamp_prescaler: CLK_PER_US must be positive");
   end

   logic             int_us;
   logic             us_pulse;
   logic [RES_W-1:0] res_eff;
   logic [RES_W-1:0] rcnt_q;
   logic             at_end;

   if (CLK_PER_US == 1) begin : g_div_bypass
      assign int_us = 1'b1;
   end else begin : g_div_count
      logic [US_W-1:0] ucnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ucnt_q <= '0;
         end else if (restart_i || ucnt_q == US_W'(CLK_PER_US - 1)) begin
            ucnt_q <= '0;
         end else begin
            ucnt_q <= ucnt_q + 1'b1;
         end
      end
      assign int_us = (ucnt_q == US_W'(CLK_PER_US - 1));
   end

   assign us_pulse = (src_i == SRC_EXTERNAL) ? ext_us_i : int_us;
   assign res_eff  = (res_i == '0) ? RES_W'(1) : res_i;
   assign at_end   = (rcnt_q >= res_eff - RES_W'(1));
   assign tick_o   = us_pulse & at_end & ~restart_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rcnt_q <= '0;
      end else if (restart_i) begin
         rcnt_q <= '0;
      end else if (us_pulse) begin
         rcnt_q <= at_end ? '0 : rcnt_q + 1'b1;
      end
   end

   AST_REST_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |-> !tick_o); // R5

endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (clear_i) begin
         count_q <= '0;
      end else if (tick_i) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;

   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> count_q == '0); // R5

   AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && tick_i) |=> count_q == $past(count_q) + CNT_W'(1)); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !tick_i) |=> $stable(count_q)); // R2

endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("stamp_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [AW:0]      lvl_q;
   logic             do_push, do_pop;

   assign empty_o = (lvl_q == '0);
   assign full_o  = (lvl_q == (AW+1)'(DEPTH));
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;
   assign dout_o  = mem_q[rptr_q];

   always_ff @(posedge clk_i) begin
      if (do_push) begin
         mem_q[wptr_q] <= din_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr_q <= '0;
         rptr_q <= '0;
         lvl_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && push_i && !pop_i) |=> full_o && $stable(wptr_q)); // R10

   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && pop_i && !push_i) |=> empty_o && $stable(rptr_q)); // R10

   AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_q <= (AW+1)'(DEPTH)); // R10

endmodule

// File: rtl/rx_stamp_unit.sv
module rx_stamp_unit
   import rx_stamp_pkg::*;
#(
   parameter int CLK_PER_US  = 50,
   parameter int NUM_RX      = 8,
   parameter int CNT_W       = 32,
   parameter int RES_W       = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    src_sel_i,
   input  logic [RES_W-1:0]        res_i,
   input  logic                    ext_clk_i,
   input  logic                    ext_rst_i,
   input  logic                    ext_rst_en_i,
   input  logic                    host_clr_i,
   input  logic                    host_rd_lo_i,
   output logic [CNT_W/2-1:0]      host_lo_o,
   output logic [CNT_W/2-1:0]      host_hi_o,
   input  logic [NUM_RX-1:0]       rx_strobe_i,
   input  logic [NUM_RX-1:0]       rx_pop_i,
   output logic [NUM_RX*CNT_W-1:0] rx_stamp_o,
   output logic [NUM_RX-1:0]       rx_empty_o,
   output logic [NUM_RX-1:0]       rx_full_o
);

   localparam int HALF = CNT_W / 2;

   if (CNT_W < 2 || (CNT_W % 2) != 0) begin : g_bad_width
      $error("rx_stamp_unit: CNT_W must be even and at least 2");
   end
   if (NUM_RX < 1) begin : g_bad_rx
      $error("rx_stamp_unit: NUM_RX must be positive");
   end

   logic             ext_us_rise;
   logic             ext_rst_rise;
   logic             clear;
   logic             tick;
   logic [CNT_W-1:0] count;
   logic [HALF-1:0]  snap_hi_q;

   stamp_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_clk_i),
      .rise_o  (ext_us_rise)
   );

   stamp_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_rst (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_rst_i),
      .rise_o  (ext_rst_rise)
   );

   assign clear = host_clr_i | (ext_rst_en_i & ext_rst_rise);

   stamp_prescaler #(.CLK_PER_US(CLK_PER_US), .RES_W(RES_W)) i_prescaler (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (clear),
      .src_i     (stamp_src_e'(src_sel_i)),
      .ext_us_i  (ext_us_rise),
      .res_i     (res_i),
      .tick_o    (tick)
   );

   stamp_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .tick_i  (tick),
      .count_o (count)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_hi_q <= '0;
      end else if (host_rd_lo_i) begin
         snap_hi_q <= count[CNT_W-1:HALF];
      end
   end

   assign host_lo_o = count[HALF-1:0];
   assign host_hi_o = snap_hi_q;

   for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
      stamp_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .push_i  (rx_strobe_i[g]),
         .din_i   (count),
         .pop_i   (rx_pop_i[g]),
         .dout_o  (rx_stamp_o[g*CNT_W +: CNT_W]),
         .empty_o (rx_empty_o[g]),
         .full_o  (rx_full_o[g])
      );
   end

   AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !host_rd_lo_i |=> $stable(snap_hi_q)); // R11

   AST_EXT_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_rst_en_i && ext_rst_rise) |=> count == '0); // R6

endmodule

// File: tb/test_rx_stamp_unit.sv
module test_rx_stamp_unit;

   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 2;
   localparam int NRX   = 3;
   localparam int CW    = 8;
   localparam int HW    = CW / 2;
   localparam int DEPTH = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            src_sel = 1'b0;
   logic [7:0]      res = 8'd1;
   logic            ext_clk = 1'b0;
   logic            ext_rst = 1'b0;
   logic            ext_rst_en = 1'b0;
   logic            host_clr = 1'b0;
   logic            host_rd_lo = 1'b0;
   logic [HW-1:0]   host_lo, host_hi;
   logic [NRX-1:0]  strobe = '0;
   logic [NRX-1:0]  pop = '0;
   logic [NRX*CW-1:0] stamp;
   logic [NRX-1:0]  empty, full;

   int vecs = 0;
   int miss = 0;
   int cyc  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_stamp_unit #(
      .CLK_PER_US(DIV), .NUM_RX(NRX), .CNT_W(CW), .RES_W(8),
      .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)
   ) i_rx_stamp_unit (
      .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .res_i(res),
      .ext_clk_i(ext_clk), .ext_rst_i(ext_rst), .ext_rst_en_i(ext_rst_en),
      .host_clr_i(host_clr), .host_rd_lo_i(host_rd_lo),
      .host_lo_o(host_lo), .host_hi_o(host_hi),
      .rx_strobe_i(strobe), .rx_pop_i(pop), .rx_stamp_o(stamp),
      .rx_empty_o(empty), .rx_full_o(full)
   );

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic go(input int k);
      while (cyc < k) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic do_clear();
      @(negedge clk);
      host_clr = 1'b1;
      @(negedge clk);
      host_clr = 1'b0;
      cyc = 0;
   endtask

   function automatic int head(input int i);
      return int'(stamp[i*CW +: CW]);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      int nlist[6];
      nlist = '{1, 2, 3, 0, 7, 5};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lo", int'(host_lo), 0);
      chk("R1 hi", int'(host_hi), 0);
      chk("R1 empty", int'(empty), 7);
      chk("R1 full", int'(full), 0);

      // R2 / R3: per-cycle sweep of the internal divider
      foreach (nlist[j]) begin
         int neff;
         int per;
         neff = (nlist[j] == 0) ? 1 : nlist[j];
         per  = DIV * neff;
         res  = 8'(nlist[j]);
         do_clear();
         for (int k = 0; k <= 3 * per + 1; k++) begin
            go(k);
            chk(nlist[j] == 0 ? "R3 res0" : "R2 sweep", int'(host_lo), (k / per) % 16);
         end
      end
      // R2 large resolution boundary
      res = 8'd255;
      do_clear();
      go(509); chk("R2 n255 before", int'(host_lo), 0);
      go(510); chk("R2 n255 step", int'(host_lo), 1);
      go(1019); chk("R2 n255 before2", int'(host_lo), 1);
      go(1020); chk("R2 n255 step2", int'(host_lo), 2);

      // R11 split read, R7 wrap, R8 capture
      res = 8'd1;
      do_clear();
      go(400); host_rd_lo = 1'b1;
      go(401); host_rd_lo = 1'b0;
      chk("R11 hi latched", int'(host_hi), 12);
      go(480);
      chk("R11 hi held", int'(host_hi), 12);
      chk("R11 lo live", int'(host_lo), 0);
      go(510); strobe = 3'b001;
      go(511); strobe = 3'b000;
      go(512); strobe = 3'b001;
      go(513); strobe = 3'b000;
      chk("R7 pre-wrap", head(0), 255);
      pop = 3'b001;
      go(514); pop = 3'b000;
      chk("R7 wrapped", head(0), 0);
      pop = 3'b001;
      go(515); pop = 3'b000;
      chk("R8 drained", int'(empty[0]), 1);

      // R8 order, R10 full / empty handling on queue 1
      do_clear();
      for (int s = 0; s < 5; s++) begin
         go(2 * s + 1); strobe = 3'b010;
         go(2 * s + 2); strobe = 3'b000;
      end
      chk("R10 full flag", int'(full[1]), 1);
      chk("R10 head kept", head(1), 0);
      pop = 3'b010;
      for (int s = 0; s < DEPTH; s++) begin
         chk("R8 order", head(1), s);
         go(cyc + 1);
      end
      chk("R10 empty after pops", int'(empty[1]), 1);
      go(cyc + 2);
      pop = 3'b000;
      chk("R10 pop empty ignored", int'(empty[1]), 1);
      go(20); strobe = 3'b111;
      go(21); strobe = 3'b000;
      chk("R9 rx0", head(0), 10);
      chk("R9 rx1", head(1), 10);
      chk("R9 rx2", head(2), 10);
      chk("R10 one entry", int'(empty), 0);
      pop = 3'b111;
      go(22); pop = 3'b000;
      chk("R9 drained", int'(empty), 7);

      // R6 external reset
      res = 8'd1;
      do_clear();
      go(10); res = 8'd255;
      go(14); chk("R6 frozen", int'(host_lo), 5);
      ext_rst = 1'b1;
      go(20); chk("R6 disarmed", int'(host_lo), 5);
      ext_rst = 1'b0;
      go(22); ext_rst_en = 1'b1; ext_rst = 1'b1;
      go(24); chk("R6 not yet", int'(host_lo), 5);
      go(25); chk("R6 cleared", int'(host_lo), 0);
      ext_rst = 1'b0; ext_rst_en = 1'b0;

      // R4 external reference
      src_sel = 1'b1;
      for (int r = 1; r <= 2; r++) begin
         int edges;
         edges = (r == 1) ? 5 : 6;
         res = 8'(r);
         do_clear();
         for (int e = 0; e < edges; e++) begin
            go(cyc + 3); ext_clk = 1'b1;
            go(cyc + 3); ext_clk = 1'b0;
         end
         go(cyc + 6);
         chk("R4 ext count", int'(host_lo), edges / r);
      end
      src_sel = 1'b0;

      // R5 host clear mid-count
      res = 8'd1;
      do_clear();
      go(9); chk("R5 before", int'(host_lo), 4);
      host_clr = 1'b1;
      go(10); host_clr = 1'b0;
      chk("R5 cleared", int'(host_lo), 0);
      go(11); chk("R5 restart phase", int'(host_lo), 0);
      go(12); chk("R5 first step", int'(host_lo), 1);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

endmodule